// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Port

This block models one port of a pipelined synchronous SRAM, with a small array whose size is set by parameters. All synchronous inputs are captured on the rising clock edge. This covers the address, the write data, three chip selects, two address strobes, the advance input, the per-byte write enables, their common gate and the global write-all input. The array is accessed on the edge that follows. Read data leaves through an output register, and a pipelined drive enable tells the pad logic when to turn the data drivers on.

An access begins in a cycle where an address strobe is active. Both strobes capture a new address and a new selection state. The controller strobe can start a read or a write. The processor strobe always starts a read, and it is ignored while the first chip select is inactive. In cycles with no strobe, the access continues at the held address while advance is asserted. The access is suspended while advance is not asserted. The address sequencing for bursts lives in a separate block.

After a read, a deselect keeps the data drivers on for one more data cycle before it turns them off. Banks that share a data bus can therefore switch without a dead cycle. The output enable input gates the drive signal combinationally.

Top module: `syncBurstRam`

## Requirements
- R1: When reset is released, `rdDrive` is 0 and `rdData` is all zeros, and they stay so until a read completes.
- R2: A read that starts on clock edge k puts the word on `rdData` and sets `rdDrive` to 1 after edge k+1.
- R3: If `allWrN` is 0 in a write cycle, all bytes of the word are written, whatever `byteWrN` and `byteGateN` are.
- R4: If `allWrN` is 1, byte b (bits 8b+7..8b) is written only when `byteGateN` is 0 and `byteWrN[b]` is 0. If `byteGateN` is 1, no byte is written.
- R5: A processor strobe (`cpuStrobeN`=0) while `chipSelAN`=1 is ignored. The held address and access continue as if no strobe were present.
- R6: A controller strobe (`ctlStrobeN`=0) while `chipSelAN`=1 captures a deselect. No write happens, and no new read data appears.
- R7: An accepted processor strobe always starts a read. Any write controls asserted in that cycle are ignored.
- R8: After a read, the first deselected cycle keeps `rdDrive` at 1 with unchanged `rdData` for one more data cycle. The second deselected cycle turns `rdDrive` off.
- R9: `outEnN`=1 forces `rdDrive` to 0 in the same cycle, with no clock edge needed.
- R10: With no strobe, `advN`=1 and the device selected, the cycle is a suspend. There is no array access, and `rdData` and `rdDrive` hold their values.
- R11: With no strobe, `advN`=0 and the device selected, the access repeats at the held address. It is a write if that cycle's write controls select any byte, and a read otherwise.
- R12: The device is selected only when `chipSelAN`=0, `chipSelB`=1 and `chipSelCN`=0. A strobe that captures any other combination writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the control and output registers |
| addr | input | ADDR_W | Word address |
| wrData | input | BYTES*BYTE_W | Write data |
| chipSelAN | input | 1 | Chip select A, active low; also gates the processor strobe |
| chipSelB | input | 1 | Chip select B, active high |
| chipSelCN | input | 1 | Chip select C, active low |
| ctlStrobeN | input | 1 | Controller address strobe, active low |
| cpuStrobeN | input | 1 | Processor address strobe, active low |
| advN | input | 1 | Advance, active low; continues an access in a cycle with no strobe |
| byteWrN | input | BYTES | Per-byte write enables, active low |
| byteGateN | input | 1 | Gate for the per-byte enables, active low |
| allWrN | input | 1 | Write-all control, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| rdData | output | BYTES*BYTE_W | Registered read data |
| rdDrive | output | 1 | Data driver enable for the pads |

## Verification
Every stimulus is driven at a falling edge and then registered on the next rising edge, which is edge k. Read data and the drive enable are therefore due just after edge k+1, and the bench samples them at the falling edge that follows. A write also lands at edge k+1, so a read-back strobe placed after it sees the new word. For the double-cycle deselect, the drive is checked as still on after the first deselected data edge and as off after the second. The output enable is checked a short delay after it changes, with no clock edge in between.

// File: rtl/sbrPkg.sv
package sbrPkg;

  typedef enum logic [1:0] {
    ST_DESEL = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_HOLD  = 2'd3
  } sbrCycle_t;

  typedef struct packed {
    logic loadAddr;
    logic doRead;
    logic doWrite;
  } sbrStrobes_t;

endpackage

// File: rtl/sbrCtrl.sv
module sbrCtrl
  import sbrPkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelAN,
  input  logic             chipSelB,
  input  logic             chipSelCN,
  input  logic             ctlStrobeN,
  input  logic             cpuStrobeN,
  input  logic             advN,
  input  logic [BYTES-1:0] byteWrN,
  input  logic             byteGateN,
  input  logic             allWrN,
  output sbrStrobes_t      str,
  output logic [BYTES-1:0] wrMask,
  output logic             driveQ
);

  logic             rCeAn, rCeB, rCeCn, rCtlN, rCpuN, rAdvN, rGateN, rAllN;
  logic [BYTES-1:0] rBwN;
  logic             selHeld, prevRead;
  logic             selNow, cpuGo, ctlGo;
  sbrCycle_t        curType;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rCeAn  <= 1'b1;
      rCeB   <= 1'b0;
      rCeCn  <= 1'b1;
      rCtlN  <= 1'b1;
      rCpuN  <= 1'b1;
      rAdvN  <= 1'b1;
      rGateN <= 1'b1;
      rAllN  <= 1'b1;
      rBwN   <= '1;
    end else begin
      rCeAn  <= chipSelAN;
      rCeB   <= chipSelB;
      rCeCn  <= chipSelCN;
      rCtlN  <= ctlStrobeN;
      rCpuN  <= cpuStrobeN;
      rAdvN  <= advN;
      rGateN <= byteGateN;
      rAllN  <= allWrN;
      rBwN   <= byteWrN;
    end
  end

  always_comb begin
    if (!rAllN)       wrMask = '1;
    else if (!rGateN) wrMask = ~rBwN;
    else              wrMask = '0;
    selNow = !rCeAn && rCeB && !rCeCn;
    cpuGo  = !rCpuN && !rCeAn;
    ctlGo  = !rCtlN && !cpuGo;
    if (cpuGo)         curType = selNow ? ST_READ : ST_DESEL;
    else if (ctlGo)    curType = !selNow ? ST_DESEL : ((|wrMask) ? ST_WRITE : ST_READ);
    else if (!selHeld) curType = ST_DESEL;
    else if (rAdvN)    curType = ST_HOLD;
    else               curType = (|wrMask) ? ST_WRITE : ST_READ;
    str.loadAddr = cpuGo || ctlGo;
    str.doRead   = (curType == ST_READ);
    str.doWrite  = (curType == ST_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selHeld  <= 1'b0;
      prevRead <= 1'b0;
      driveQ   <= 1'b0;
    end else begin
      if (cpuGo || ctlGo) selHeld <= selNow;
      unique case (curType)
        ST_READ:  begin driveQ <= 1'b1;     prevRead <= 1'b1; end
        ST_DESEL: begin driveQ <= prevRead; prevRead <= 1'b0; end
        ST_WRITE: begin driveQ <= 1'b0;     prevRead <= 1'b0; end
        default:  ;
      endcase
    end
  end

  // R2
  read_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    curType == ST_READ |=> driveQ);

  // R8
  drive_off_after_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveQ) |-> $past(curType) != ST_READ);

  // R7
  cpu_never_writes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rCpuN && !rCeAn) |-> !str.doWrite);

  // R10
  hold_keeps_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    curType == ST_HOLD |=> $stable(driveQ));

endmodule

// File: rtl/sbrData.sv
module sbrData
  import sbrPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] wrData,
  input  sbrStrobes_t             str,
  input  logic [BYTES-1:0]        wrMask,
  output logic [BYTES*BYTE_W-1:0] rdData
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = BYTES * BYTE_W;

  logic [ADDR_W-1:0] rAddr, heldAddr, accAddr;
  logic [DATA_W-1:0] rData, rdWord, rdReg;

  always_ff @(posedge clk) begin
    rAddr <= addr;
    rData <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             heldAddr <= '0;
    else if (str.loadAddr) heldAddr <= rAddr;
  end

  assign accAddr = str.loadAddr ? rAddr : heldAddr;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (str.doWrite && wrMask[b]) lane[accAddr] <= rData[b*BYTE_W +: BYTE_W];
    end
    assign rdWord[b*BYTE_W +: BYTE_W] = lane[accAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdReg <= '0;
    else if (str.doRead) rdReg <= rdWord;
  end

  assign rdData = rdReg;

  // R10
  out_reg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.doRead |=> $stable(rdReg));

endmodule

// File: rtl/syncBurstRam.sv
module syncBurstRam
  import sbrPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] wrData,
  input  logic                    chipSelAN,
  input  logic                    chipSelB,
  input  logic                    chipSelCN,
  input  logic                    ctlStrobeN,
  input  logic                    cpuStrobeN,
  input  logic                    advN,
  input  logic [BYTES-1:0]        byteWrN,
  input  logic                    byteGateN,
  input  logic                    allWrN,
  input  logic                    outEnN,
  output logic [BYTES*BYTE_W-1:0] rdData,
  output logic                    rdDrive
);

  sbrStrobes_t      str;
  logic [BYTES-1:0] wrMask;
  logic             driveQ;

  sbrCtrl #(.BYTES(BYTES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .chipSelAN(chipSelAN), .chipSelB(chipSelB), .chipSelCN(chipSelCN),
    .ctlStrobeN(ctlStrobeN), .cpuStrobeN(cpuStrobeN), .advN(advN),
    .byteWrN(byteWrN), .byteGateN(byteGateN), .allWrN(allWrN),
    .str(str), .wrMask(wrMask), .driveQ(driveQ)
  );

  sbrData #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .str(str), .wrMask(wrMask), .rdData(rdData)
  );

  assign rdDrive = driveQ && !outEnN;

  // R9
  oe_gates_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !rdDrive);

endmodule

// File: tb/sim_syncBurstRam.sv
module sim_syncBurstRam;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  addr;
  logic [31:0] wrData;
  logic        chipSelAN, chipSelB, chipSelCN, ctlStrobeN, cpuStrobeN, advN;
  logic [3:0]  byteWrN;
  logic        byteGateN, allWrN, outEnN;
  logic [31:0] rdData;
  logic        rdDrive;
  int          checks = 0;
  int          errors = 0;

  always #(PERIOD/2) clk = ~clk;

  syncBurstRam u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .chipSelAN(chipSelAN), .chipSelB(chipSelB), .chipSelCN(chipSelCN),
    .ctlStrobeN(ctlStrobeN), .cpuStrobeN(cpuStrobeN), .advN(advN),
    .byteWrN(byteWrN), .byteGateN(byteGateN), .allWrN(allWrN),
    .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setIdle();
    ctlStrobeN = 1'b1; cpuStrobeN = 1'b1; advN = 1'b1;
    chipSelAN = 1'b0; chipSelB = 1'b1; chipSelCN = 1'b0;
    allWrN = 1'b1; byteGateN = 1'b1; byteWrN = 4'hF;
  endtask

  task automatic writeOp(input logic [7:0] a, input logic [31:0] d, input logic aN,
                         input logic b, input logic cN, input logic allN,
                         input logic gN, input logic [3:0] bwN);
    setIdle();
    addr = a; wrData = d; ctlStrobeN = 1'b0;
    chipSelAN = aN; chipSelB = b; chipSelCN = cN;
    allWrN = allN; byteGateN = gN; byteWrN = bwN;
    tick();
    setIdle();
    tick();
  endtask

  task automatic readCheck(input logic [7:0] a, input logic [31:0] exp, input string tag);
    setIdle();
    addr = a; cpuStrobeN = 1'b0;
    tick();
    setIdle();
    tick();
    check({tag, " data"}, rdData, exp);
    check({tag, " drive"}, {31'd0, rdDrive}, 32'd1);
  endtask

  task automatic testReset();
    setIdle(); outEnN = 1'b0; addr = '0; wrData = '0;
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick(); tick();
    check("R1 data", rdData, 32'd0);
    check("R1 drive", {31'd0, rdDrive}, 32'd0);
  endtask

  task automatic testAllWrite();
    writeOp(8'h10, 32'h11223344, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF);
    readCheck(8'h10, 32'h11223344, "R3/R2 write-all");
    writeOp(8'h20, 32'h55667788, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF);
    readCheck(8'h20, 32'h55667788, "R3 write-all overrides bytes");
  endtask

  task automatic testByteWrite();
    writeOp(8'h10, 32'hAABBCCDD, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1010);
    readCheck(8'h10, 32'h11BB33DD, "R4 bytes 0,2");
    writeOp(8'h10, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000);
    readCheck(8'h10, 32'h11BB33DD, "R4 gate off");
  endtask

  task automatic testCpuRead();
    setIdle();
    addr = 8'h10; wrData = 32'h0; cpuStrobeN = 1'b0; allWrN = 1'b0;
    tick();
    setIdle();
    tick();
    check("R7 cpu strobe reads", rdData, 32'h11BB33DD);
    readCheck(8'h10, 32'h11BB33DD, "R7 no write");
  endtask

  task automatic testContinue();
    setIdle();
    addr = 8'h10; cpuStrobeN = 1'b0;
    tick();
    addr = 8'h20; cpuStrobeN = 1'b0; chipSelAN = 1'b1; advN = 1'b0;
    tick();
    check("R2 read", rdData, 32'h11BB33DD);
    setIdle();
    tick();
    check("R5/R11 ignored strobe, continue read", rdData, 32'h11BB33DD);
    advN = 1'b0; allWrN = 1'b0; wrData = 32'h99AABBCC;
    tick();
    setIdle();
    tick();
    readCheck(8'h10, 32'h99AABBCC, "R11 continue write");
  endtask

  task automatic testSuspend();
    readCheck(8'h20, 32'h55667788, "R10 setup");
    setIdle();
    allWrN = 1'b0; wrData = 32'h0;
    repeat (3) tick();
    check("R10 data held", rdData, 32'h55667788);
    check("R10 drive held", {31'd0, rdDrive}, 32'd1);
    readCheck(8'h20, 32'h55667788, "R10 no write");
  endtask

  task automatic testOe();
    outEnN = 1'b1;
    #1;
    check("R9 oe off", {31'd0, rdDrive}, 32'd0);
    outEnN = 1'b0;
    #1;
    check("R9 oe on", {31'd0, rdDrive}, 32'd1);
  endtask

  task automatic testDcd();
    setIdle();
    addr = 8'h10; cpuStrobeN = 1'b0;
    tick();
    setIdle();
    ctlStrobeN = 1'b0; chipSelB = 1'b0;
    tick();
    check("R8 read on", {31'd0, rdDrive}, 32'd1);
    setIdle();
    tick();
    check("R8 extra cycle drive", {31'd0, rdDrive}, 32'd1);
    check("R8 extra cycle data", rdData, 32'h99AABBCC);
    tick();
    check("R8 drive off", {31'd0, rdDrive}, 32'd0);
    tick();
    check("R8 stays off", {31'd0, rdDrive}, 32'd0);
  endtask

  task automatic testCeA();
    writeOp(8'h10, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF);
    check("R6 no drive", {31'd0, rdDrive}, 32'd0);
    readCheck(8'h10, 32'h99AABBCC, "R6 no write");
  endtask

  task automatic testCeBC();
    writeOp(8'h20, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF);
    readCheck(8'h20, 32'h55667788, "R12 chip select C blocks write");
    writeOp(8'h20, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF);
    readCheck(8'h20, 32'h55667788, "R12 chip select B blocks write");
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testAllWrite();
    testByteWrite();
    testCpuRead();
    testContinue();
    testSuspend();
    testOe();
    testDcd();
    testCeA();
    testCeBC();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule